// File: doc/BRIEF.md
# Serial Memory Status and Write-Protection Controller

This block sits behind the command decoder of a serial byte-addressed memory. It keeps the status byte, decides whether each array page commit or status write may go ahead, and times the self-timed programming cycle that follows a granted commit. The decoder gives it one-cycle requests: set the write-enable latch, clear it, commit a status write (with new protection fields), or commit a page write (with the page index). The block answers each commit with a one-cycle grant or deny pulse. It then reports busy until a counter of `WC_CYCLES` clocks has elapsed.

The protection fields are a hardware-protect enable bit and a two-bit block-protect level. Their reset values are parameters. The level guards nothing, the top quarter, the top half, or the whole array. The hardware-protect enable bit arms the active-low protect pin. When the bit is 1 and the pin is low, status writes are refused but unprotected pages stay writable. Every write needs the enable latch set, and the latch clears itself when the write cycle ends.

Top module: `wprot_status_ctl`

## Requirements
- R1: After reset, `status_o` equals {INIT_WPEN, 000, INIT_BP, 0, 0} (00h with the defaults), `busy_o` is 0 and no grant or deny pulse is present.
- R2: While idle, status bit 7 is the protect-enable bit, bits 6..4 read 0, bits 3..2 are the block level (bit 3 the high bit), bit 1 is the write-enable latch and bit 0 reads 0.
- R3: A grant starts a write cycle: `busy_o` is 1 for exactly WC_CYCLES clock cycles, starting in the cycle of the grant pulse, and `status_o` reads FFh throughout.
- R4: A set request makes status bit 1 equal 1 and a clear request makes it 0, whatever the level of `wp_n_i`.
- R5: The write-enable latch reads 0 once any write cycle has completed.
- R6: A status or page commit made while the write-enable latch is 0 is denied and leaves the status unchanged.
- R7: A page commit is denied when its page is protected. Level 00 protects nothing. Level 01 protects pages at or above three quarters of the page range. Level 10 protects the upper half. Level 11 protects every page. Any other page commit with the latch set is granted.
- R8: When the protect-enable bit is 1 and `wp_n_i` is 0, a status write is denied, while a page commit to an unprotected page is still granted.
- R9: `wp_n_i` is evaluated in the cycle of the status commit. A low level then denies the write; a change during the following write cycle does not alter the value that was granted.
- R10: While busy, set and clear requests have no effect and every commit is denied.
- R11: Grant and deny are single-cycle pulses in the cycle after the commit and are never high together.
- R12: A granted status write loads only the protect-enable bit and the block level, and these values are visible once busy ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_wel_i | input | 1 | Request to set the write-enable latch |
| clr_wel_i | input | 1 | Request to clear the write-enable latch |
| stat_wr_i | input | 1 | Commit of a status write |
| new_wpen_i | input | 1 | Protect-enable value carried by the status write |
| new_bp_i | input | 2 | Block-protect level carried by the status write |
| page_wr_i | input | 1 | Commit of an array page write |
| page_i | input | ADDR_W-PAGE_W | Index of the page being committed |
| wp_n_i | input | 1 | Active-low hardware protect pin level |
| status_o | output | 8 | Status byte for reads |
| grant_o | output | 1 | Commit accepted, write cycle started |
| deny_o | output | 1 | Commit refused |
| busy_o | output | 1 | Write cycle in progress |

## Verification
A latch, protection bit or level that holds the wrong value shows up on `status_o` in the cycle after the request that set it. A wrong value also flips the grant or deny answer to the very next commit, one cycle after that commit. A wrong cycle counter shows up as a busy window of the wrong length, or as a latch still set after busy falls. The directed scenarios walk every protection level across its page boundaries. They drive the protect pin both at the commit and in the middle of a cycle, and they fire requests while the block is busy.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    // Status byte bit positions (read side decodes these)
    localparam int STAT_WPEN  = 7;
    localparam int STAT_BP_HI = 3;
    localparam int STAT_BP_LO = 2;
    localparam int STAT_WEL   = 1;
    localparam int STAT_RDY   = 0;

    typedef struct packed {
        logic       wel;
        logic       wpen;
        logic [1:0] bp;
        logic       grant;
        logic       deny;
    } wp_state_t;

    function automatic logic [7:0] pack_status(input logic wpen, input logic [1:0] bp,
                                               input logic wel);
        logic [7:0] s;
        s             = 8'h00;
        s[STAT_WPEN]  = wpen;
        s[STAT_BP_HI] = bp[1];
        s[STAT_BP_LO] = bp[0];
        s[STAT_WEL]   = wel;
        s[STAT_RDY]   = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/wprot_range_chk.sv
module wprot_range_chk #(
    parameter int PG_W = 9
) (
    input  logic [1:0]      bp_i,
    input  logic [PG_W-1:0] page_i,
    output logic            hit_o
);
    // Level boundaries, all page aligned
    localparam logic [PG_W-1:0] HALF_PG = PG_W'(1) << (PG_W - 1);
    localparam logic [PG_W-1:0] QTR3_PG = PG_W'(3) << (PG_W - 2);

    always_comb begin
        unique case (bp_i)
            2'b00:   hit_o = 1'b0;
            2'b01:   hit_o = (page_i >= QTR3_PG);
            2'b10:   hit_o = (page_i >= HALF_PG);
            default: hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wprot_cycle_timer.sv
module wprot_cycle_timer #(
    parameter int WC_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(WC_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i && (cnt_q == '0)) begin
            cnt_d = CW'(WC_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/wprot_status_ctl.sv
module wprot_status_ctl #(
    parameter int         ADDR_W    = 17,
    parameter int         PAGE_W    = 8,
    parameter int         WC_CYCLES = 20,
    parameter logic       INIT_WPEN = 1'b0,
    parameter logic [1:0] INIT_BP   = 2'b00
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_wel_i,
    input  logic                     clr_wel_i,
    input  logic                     stat_wr_i,
    input  logic                     new_wpen_i,
    input  logic [1:0]               new_bp_i,
    input  logic                     page_wr_i,
    input  logic [ADDR_W-PAGE_W-1:0] page_i,
    input  logic                     wp_n_i,
    output logic [7:0]               status_o,
    output logic                     grant_o,
    output logic                     deny_o,
    output logic                     busy_o
);
    import wprot_pkg::*;

    localparam int PG_W = ADDR_W - PAGE_W;

    wp_state_t st_d, st_q;
    logic      start_wc;
    logic      wc_busy;
    logic      wc_done;
    logic      page_prot;
    logic      hw_lock;

    wprot_range_chk #(.PG_W(PG_W)) range_i (
        .bp_i   (st_q.bp),
        .page_i (page_i),
        .hit_o  (page_prot)
    );

    wprot_cycle_timer #(.WC_CYCLES(WC_CYCLES)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_wc),
        .busy_o  (wc_busy),
        .done_o  (wc_done)
    );

    assign hw_lock = st_q.wpen & ~wp_n_i;

    always_comb begin
        st_d       = st_q;
        st_d.grant = 1'b0;
        st_d.deny  = 1'b0;
        start_wc   = 1'b0;

        if (wc_busy) begin
            // only status reads are served during a cycle
            if (stat_wr_i || page_wr_i) st_d.deny = 1'b1;
        end else if (stat_wr_i) begin
            if (st_q.wel && !hw_lock) begin
                st_d.grant = 1'b1;
                st_d.wpen  = new_wpen_i;
                st_d.bp    = new_bp_i;
                start_wc   = 1'b1;
            end else begin
                st_d.deny  = 1'b1;
            end
        end else if (page_wr_i) begin
            if (st_q.wel && !page_prot) begin
                st_d.grant = 1'b1;
                start_wc   = 1'b1;
            end else begin
                st_d.deny  = 1'b1;
            end
        end else if (clr_wel_i) begin
            st_d.wel = 1'b0;
        end else if (set_wel_i) begin
            st_d.wel = 1'b1;
        end

        if (wc_done) st_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wel   <= 1'b0;
            st_q.wpen  <= INIT_WPEN;
            st_q.bp    <= INIT_BP;
            st_q.grant <= 1'b0;
            st_q.deny  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = wc_busy ? 8'hFF : pack_status(st_q.wpen, st_q.bp, st_q.wel);
    assign grant_o  = st_q.grant;
    assign deny_o   = st_q.deny;
    assign busy_o   = wc_busy;
endmodule

// File: rtl/wprot_status_ctl_chk.sv
module wprot_status_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stat_wr_i,
    input logic       page_wr_i,
    input logic       clr_wel_i,
    input logic       wp_n_i,
    input logic [7:0] status_o,
    input logic       grant_o,
    input logic       deny_o,
    input logic       busy_o
);
    p_ff_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> status_o == 8'hFF);

    p_grant_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> busy_o);

    p_idle_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (status_o[6:4] == 3'b000 && !status_o[0]));

    p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && deny_o));

    p_wel_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !status_o[1]);

    p_clr_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wel_i && !busy_o && !stat_wr_i && !page_wr_i) |=> !status_o[1]);

    p_no_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_wr_i || page_wr_i) && !busy_o && !status_o[1]) |=> deny_o);

    p_all_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (page_wr_i && !stat_wr_i && !busy_o && status_o[3:2] == 2'b11) |=> deny_o);

    p_hw_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && !busy_o && status_o[7] && !wp_n_i) |=> deny_o);

    p_busy_deny_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (stat_wr_i || page_wr_i)) |=> deny_o);
endmodule

bind wprot_status_ctl wprot_status_ctl_chk chk_i (.*);

// File: tb/wprot_status_ctl_tb_top.sv
`timescale 1ns/1ps
module wprot_status_ctl_tb_top;
    localparam int WC  = 12;
    localparam int PGW = 9;

    localparam int K_SET  = 0;
    localparam int K_CLR  = 1;
    localparam int K_STAT = 2;
    localparam int K_PAGE = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           set_wel_i = 1'b0, clr_wel_i = 1'b0, stat_wr_i = 1'b0, page_wr_i = 1'b0;
    logic           new_wpen_i = 1'b0;
    logic [1:0]     new_bp_i = 2'b00;
    logic [PGW-1:0] page_i = '0;
    logic           wp_n_i = 1'b1;
    logic [7:0]     status_o;
    logic           grant_o, deny_o, busy_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wprot_status_ctl #(.ADDR_W(17), .PAGE_W(8), .WC_CYCLES(WC)) dut_i (
        .clk(clk), .rst_n(rst_n), .set_wel_i(set_wel_i), .clr_wel_i(clr_wel_i),
        .stat_wr_i(stat_wr_i), .new_wpen_i(new_wpen_i), .new_bp_i(new_bp_i),
        .page_wr_i(page_wr_i), .page_i(page_i), .wp_n_i(wp_n_i),
        .status_o(status_o), .grant_o(grant_o), .deny_o(deny_o), .busy_o(busy_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic req(input int kind, input logic nw, input logic [1:0] nb,
                       input logic [PGW-1:0] pg, output logic g, output logic dn);
        new_wpen_i = nw; new_bp_i = nb; page_i = pg;
        case (kind)
            K_SET:   set_wel_i = 1'b1;
            K_CLR:   clr_wel_i = 1'b1;
            K_STAT:  stat_wr_i = 1'b1;
            default: page_wr_i = 1'b1;
        endcase
        @(negedge clk);
        g = grant_o; dn = deny_o;
        set_wel_i = 1'b0; clr_wel_i = 1'b0; stat_wr_i = 1'b0; page_wr_i = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic write_status(input logic w, input logic [1:0] b, input string tag);
        logic g, dn;
        int n;
        req(K_SET, 0, 0, 0, g, dn);
        req(K_STAT, w, b, 0, g, dn);
        chk({tag, " status write granted"}, g, 1'b1);
        wait_idle(n);
        chk({tag, " status after write"}, status_o, {w, 3'b000, b, 2'b00});
    endtask

    task automatic t_reset;
        chk("R1 reset status", status_o, 8'h00);
        chk("R1 reset busy", busy_o, 1'b0);
        chk("R1 reset pulses", {grant_o, deny_o}, 2'b00);
    endtask

    task automatic t_wel;
        logic g, dn;
        req(K_PAGE, 0, 0, 9'h010, g, dn);
        chk("R6 commit without latch denied", {g, dn}, 2'b01);
        chk("R6 status unchanged", status_o, 8'h00);
        req(K_SET, 0, 0, 0, g, dn);
        chk("R4 set latch", status_o, 8'h02);
        wp_n_i = 1'b0;
        req(K_CLR, 0, 0, 0, g, dn);
        chk("R4 clear latch with pin low", status_o, 8'h00);
        wp_n_i = 1'b1;
    endtask

    task automatic t_cycle;
        logic g, dn;
        int n;
        req(K_SET, 0, 0, 0, g, dn);
        req(K_PAGE, 0, 0, 9'h000, g, dn);
        chk("R11 grant pulse", {g, dn}, 2'b10);
        chk("R3 status all ones while busy", status_o, 8'hFF);
        chk("R3 busy with grant", busy_o, 1'b1);
        @(negedge clk);
        chk("R11 grant lasts one cycle", grant_o, 1'b0);
        wait_idle(n);
        chk("R3 busy length", n + 1, WC);
        chk("R5 latch cleared after cycle", status_o, 8'h00);
    endtask

    task automatic t_field_load;
        write_status(1'b1, 2'b11, "R12");
        chk("R12 only enable and level loaded", status_o, 8'h8C);
    endtask

    task automatic t_levels;
        logic [PGW-1:0] pgs [6];
        logic g, dn, prot;
        int n;
        pgs[0] = 9'h000; pgs[1] = 9'h0FF; pgs[2] = 9'h100;
        pgs[3] = 9'h17F; pgs[4] = 9'h180; pgs[5] = 9'h1FF;
        for (int bp = 0; bp < 4; bp++) begin
            write_status(1'b0, 2'(bp), "R7");
            for (int i = 0; i < 6; i++) begin
                prot = (bp == 3) || (bp == 2 && pgs[i][8]) || (bp == 1 && pgs[i][8:7] == 2'b11);
                req(K_SET, 0, 0, 0, g, dn);
                req(K_PAGE, 0, 0, pgs[i], g, dn);
                chk($sformatf("R7 level %0d page %0h", bp, pgs[i]), {g, dn}, {~prot, prot});
                if (g) wait_idle(n);
                else   req(K_CLR, 0, 0, 0, g, dn);
                chk("R7 level kept", status_o, {6'b000000, 2'(bp)} << 2);
            end
        end
        write_status(1'b0, 2'b00, "R7");
    endtask

    task automatic t_hw_lock;
        logic g, dn;
        int n;
        write_status(1'b1, 2'b00, "R8");
        wp_n_i = 1'b0;
        req(K_SET, 0, 0, 0, g, dn);
        req(K_STAT, 0, 2'b00, 0, g, dn);
        chk("R8 status write locked", {g, dn}, 2'b01);
        chk("R8 status kept", status_o, 8'h82);
        req(K_PAGE, 0, 0, 9'h1FF, g, dn);
        chk("R8 unprotected page still writable", {g, dn}, 2'b10);
        wait_idle(n);
        chk("R8 after page cycle", status_o, 8'h80);
        req(K_SET, 0, 0, 0, g, dn);
        req(K_STAT, 1, 2'b01, 0, g, dn);
        chk("R8 level change locked", {g, dn}, 2'b01);
        req(K_CLR, 0, 0, 0, g, dn);
        chk("R4 clear under lock", status_o, 8'h80);
    endtask

    task automatic t_pin_timing;
        logic g, dn;
        int n;
        wp_n_i = 1'b1;
        req(K_SET, 0, 0, 0, g, dn);
        wp_n_i = 1'b0;
        @(negedge clk);
        req(K_STAT, 1, 2'b10, 0, g, dn);
        chk("R9 pin low at commit denies", {g, dn}, 2'b01);
        wp_n_i = 1'b1;
        req(K_STAT, 1, 2'b01, 0, g, dn);
        chk("R9 pin high at commit grants", {g, dn}, 2'b10);
        wp_n_i = 1'b0;
        wait_idle(n);
        chk("R9 pin change mid-cycle no effect", status_o, 8'h84);
        wp_n_i = 1'b1;
    endtask

    task automatic t_busy;
        logic g, dn;
        int n;
        write_status(1'b0, 2'b00, "R10");
        req(K_SET, 0, 0, 0, g, dn);
        req(K_PAGE, 0, 0, 9'h000, g, dn);
        chk("R10 cycle started", g, 1'b1);
        req(K_SET, 0, 0, 0, g, dn);
        req(K_STAT, 1, 2'b11, 0, g, dn);
        chk("R10 status commit while busy", {g, dn}, 2'b01);
        req(K_PAGE, 0, 0, 9'h001, g, dn);
        chk("R10 page commit while busy", {g, dn}, 2'b01);
        wait_idle(n);
        chk("R10 requests while busy ignored", status_o, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wel();
        t_cycle();
        t_field_load();
        t_levels();
        t_hw_lock();
        t_pin_timing();
        t_busy();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule